// File: doc/BRIEF.md
# Quadword Buffered Byte Stream Reader

This block turns a stream of 128-bit quadwords held in memory into byte reads of any size from 1 to 16 bytes. A one-quadword staging register and a byte cursor sit between the memory side and the consumer. When the cursor runs off the end of the staging register, the block fetches the next quadword from an address that walks upward in 16-byte steps. Once it reaches a configured end address it stops fetching. A read that straddles two quadwords is assembled in pieces. The bytes come back little-endian in the low end of a 128-bit response word.

Software loads a transfer with a start address, an end address and a flag. The flag says that the first quadword carries an 8-byte transfer tag that must never reach the consumer. The block reports how many bytes it still holds in reserve. Between packets, the consumer can ask for the cursor to be rounded up to the next 32-bit boundary. A request larger than the reported reserve is held off with a stall indication. A fetch needed after the end address has been reached raises a sticky error.

Top module: `qw_byte_reader`

## Requirements
- R1: After reset the staging register is empty (cursor at 16), `avail_bytes` is 0, and `rsp_valid`, `mem_req` and `err_flag` are low.
- R2: A `cfg_load` pulse while idle empties the staging register, sets the next fetch address to `cfg_start`, latches `cfg_end` and `cfg_tag`, and clears `err_flag`. After it, `avail_bytes` equals `cfg_end - cfg_start`.
- R3: An accepted read of N bytes (`rd_len` 1..15 means N, 0 means 16) returns the next N stream bytes in `rsp_data`. Stream byte k sits in bits 8k+7:8k, and every byte above N-1 is zero.
- R4: A fetch is made only when bytes are needed and the staging register is empty. `mem_req` stays high with a stable `mem_addr` until `mem_rsp_valid`, and successive fetch addresses step by 16 from `cfg_start`.
- R5: A read that crosses a quadword boundary takes the bytes left in the staging register, fetches the next quadword, then continues from its byte 0.
- R6: With `cfg_tag` set, the first fetch after configuration puts the cursor at 8, so bytes 0..7 of that quadword never appear in a response. Later fetches start at 0.
- R7: `avail_bytes` always equals (end address minus next fetch address) plus (16 minus cursor). It never rises except through `cfg_load`.
- R8: A read is accepted (`rd_ready` high) only when idle and when `avail_bytes` is at least N. When idle with `rd_valid` high and too few bytes, `rd_stall` is high and the request leaves `avail_bytes` unchanged.
- R9: A fetch needed while the next fetch address has reached the end address sets `err_flag` and issues no `mem_req`. The response then carries only the bytes collected so far, with zeros above them. `err_flag` stays high until the next `cfg_load`.
- R10: An `align_req` pulse while idle rounds a cursor below 16 up to the next multiple of 4. An empty staging register is left unchanged.
- R11: Every accepted read yields exactly one `rsp_valid` pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Load a new transfer (taken when idle) |
| cfg_start | input | ADDR_W | Byte address of the first quadword, 16-byte aligned |
| cfg_end | input | ADDR_W | Byte address one past the last quadword, 16-byte aligned |
| cfg_tag | input | 1 | First quadword carries an 8-byte tag to skip |
| align_req | input | 1 | Round the cursor up to a 4-byte boundary (taken when idle) |
| rd_valid | input | 1 | Read request valid |
| rd_len | input | LEN_W | Byte count, 0 encodes 16 |
| rd_ready | output | 1 | Read request accepted this cycle |
| rd_stall | output | 1 | Pending request exceeds the available bytes |
| rsp_valid | output | 1 | Response word valid for one cycle |
| rsp_data | output | 8*BYTES | Returned bytes, little-endian, zero-filled above |
| avail_bytes | output | ADDR_W+1 | Bytes not yet delivered in the transfer |
| err_flag | output | 1 | Sticky: fetch attempted past the end address |
| mem_req | output | 1 | Quadword fetch request |
| mem_addr | output | ADDR_W | Fetch byte address |
| mem_rsp_valid | input | 1 | Fetch data valid |
| mem_rsp_data | input | 8*BYTES | Fetched quadword |

## Verification
A cursor or fetch address that drifts shows up first in `avail_bytes`, which the bench compares after every read, alignment and configuration. An off-by-one is therefore visible in the first idle cycle after the operation that caused it. Wrong byte selection or a missed tag skip corrupts `rsp_data` in the response to that same read, because every memory byte carries a value derived from its address. A fetch address that skips or repeats is caught at the very fetch where it happens. A missing or extra fetch at the end address is caught at the following response through `err_flag` and the zeroed upper bytes.

// File: rtl/qbr_pkg.sv
// Shared types for the quadword byte reader.
// Assumes: nothing beyond the importing module's clocking.
package qbr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a read, alignment or configuration
        ST_COPY = 2'd1,   // moving bytes from staging register to response
        ST_FILL = 2'd2,   // waiting on a quadword from memory
        ST_RESP = 2'd3    // presenting the assembled response
    } qbr_state_t;

endpackage

// File: rtl/qbr_src_ctrl.sv
// Source address tracker: holds the next fetch address, the end address
// and the pending tag-skip flag, and reports the bytes left to fetch.
// Assumes start and end are BYTES-aligned with start <= end.
module qbr_src_ctrl #(
    parameter int ADDR_W = 16,
    parameter int BYTES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_go,
    input  logic [ADDR_W-1:0] cfg_start,
    input  logic [ADDR_W-1:0] cfg_end,
    input  logic              cfg_tag,
    input  logic              advance,
    output logic [ADDR_W-1:0] next_addr,
    output logic [ADDR_W-1:0] remaining,
    output logic              at_end,
    output logic              tag_pend
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BYTES);

    logic [ADDR_W-1:0] end_addr;

    // Purpose: load a transfer or step past a fetched quadword.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_addr <= '0;
            end_addr  <= '0;
            tag_pend  <= 1'b0;
        end else if (cfg_go) begin
            next_addr <= cfg_start;
            end_addr  <= cfg_end;
            tag_pend  <= cfg_tag;
        end else if (advance) begin
            next_addr <= next_addr + STEP;
            tag_pend  <= 1'b0;
        end
    end

    // Purpose: derive the fetch-side byte count and the end condition.
    always_comb begin
        at_end    = (next_addr >= end_addr);
        remaining = at_end ? '0 : (end_addr - next_addr);
    end

endmodule

// File: rtl/qbr_stage.sv
// Staging register: one quadword plus a byte cursor. The cursor value
// BYTES means empty. Handles load (with optional leading skip), consume
// and round-up alignment.
// Assumes ALIGN is a power of two no larger than BYTES.
module qbr_stage #(
    parameter int BYTES     = 16,
    parameter int TAG_BYTES = 8,
    parameter int ALIGN     = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          load,
    input  logic [8*BYTES-1:0]            load_data,
    input  logic                          skip,
    input  logic                          consume,
    input  logic [$clog2(BYTES):0]        take,
    input  logic                          align,
    output logic [8*BYTES-1:0]            qw,
    output logic [$clog2(BYTES):0]        pos,
    output logic                          empty
);

    localparam int POS_W = $clog2(BYTES) + 1;
    localparam logic [POS_W-1:0] FULL_POS = POS_W'(BYTES);
    localparam logic [POS_W-1:0] SKIP_POS = POS_W'(TAG_BYTES);
    localparam logic [POS_W-1:0] AL_MASK  = POS_W'(ALIGN - 1);

    logic [POS_W-1:0] pos_up;

    // Purpose: cursor rounded up to the alignment boundary.
    always_comb begin
        pos_up = (pos + AL_MASK) & ~AL_MASK;
    end

    // Purpose: update quadword and cursor; one action per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qw  <= '0;
            pos <= FULL_POS;
        end else if (clear) begin
            pos <= FULL_POS;
        end else if (load) begin
            qw  <= load_data;
            pos <= skip ? SKIP_POS : '0;
        end else if (consume) begin
            pos <= pos + take;
        end else if (align && (pos < FULL_POS)) begin
            pos <= pos_up;
        end
    end

    assign empty = (pos >= FULL_POS);

endmodule

// File: rtl/qbr_gather.sv
// Response assembler: appends a run of staging bytes to an accumulator
// at its current fill point. Bytes above the fill point stay zero.
// Assumes fill + take never exceeds BYTES.
module qbr_gather #(
    parameter int BYTES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   go,
    input  logic [8*BYTES-1:0]     src,
    input  logic [$clog2(BYTES):0] pos,
    input  logic [$clog2(BYTES):0] take,
    output logic [8*BYTES-1:0]     acc
);

    localparam int POS_W = $clog2(BYTES) + 1;
    localparam int IDX_W = $clog2(BYTES);

    logic [POS_W-1:0]   fill;
    logic [POS_W-1:0]   fill_end;
    logic [8*BYTES-1:0] acc_n;

    // Purpose: place each selected staging byte at its response lane.
    always_comb begin
        fill_end = fill + take;
        acc_n    = acc;
        for (int i = 0; i < BYTES; i++) begin
            logic [IDX_W-1:0] idx;
            idx = IDX_W'(pos + POS_W'(i) - fill);
            if ((POS_W'(i) >= fill) && (POS_W'(i) < fill_end))
                acc_n[8*i +: 8] = src[8*idx +: 8];
        end
    end

    // Purpose: clear on a new read, append on each copy step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            fill <= '0;
        end else if (clear) begin
            acc  <= '0;
            fill <= '0;
        end else if (go) begin
            acc  <= acc_n;
            fill <= fill_end;
        end
    end

endmodule

// File: rtl/qw_byte_reader.sv
// Top of the quadword byte reader: accepts byte reads, copies them out
// of the staging register in pieces, fetches quadwords on demand and
// reports the bytes still available.
// Assumes cfg_start/cfg_end are 16-byte aligned and cfg_start <= cfg_end.
module qw_byte_reader #(
    parameter int ADDR_W    = 16,
    parameter int BYTES     = 16,
    parameter int TAG_BYTES = 8,
    parameter int ALIGN     = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_load,
    input  logic [ADDR_W-1:0]         cfg_start,
    input  logic [ADDR_W-1:0]         cfg_end,
    input  logic                      cfg_tag,
    input  logic                      align_req,
    input  logic                      rd_valid,
    input  logic [$clog2(BYTES)-1:0]  rd_len,
    output logic                      rd_ready,
    output logic                      rd_stall,
    output logic                      rsp_valid,
    output logic [8*BYTES-1:0]        rsp_data,
    output logic [ADDR_W:0]           avail_bytes,
    output logic                      err_flag,
    output logic                      mem_req,
    output logic [ADDR_W-1:0]         mem_addr,
    input  logic                      mem_rsp_valid,
    input  logic [8*BYTES-1:0]        mem_rsp_data
);

    import qbr_pkg::*;

    localparam int POS_W = $clog2(BYTES) + 1;
    localparam int AV_W  = ADDR_W + 1;
    localparam logic [POS_W-1:0] FULL_POS = POS_W'(BYTES);

    qbr_state_t        st, st_n;
    logic [POS_W-1:0]  rem;
    logic [POS_W-1:0]  len_eff;
    logic [POS_W-1:0]  space;
    logic [POS_W-1:0]  take;
    logic [POS_W-1:0]  pos;
    logic [8*BYTES-1:0] qw;
    logic [ADDR_W-1:0] next_addr;
    logic [ADDR_W-1:0] remaining;
    logic              at_end, tag_pend, empty;
    logic              idle, enough, fire, cfg_go, align_go;
    logic              copy_go, fill_done, over_end;

    // Purpose: decode request, acceptance and step conditions.
    always_comb begin
        idle      = (st == ST_IDLE);
        len_eff   = (rd_len == '0) ? FULL_POS : POS_W'(rd_len);
        space     = FULL_POS - pos;
        take      = (rem < space) ? rem : space;
        avail_bytes = AV_W'(remaining) + AV_W'(space);
        enough    = (avail_bytes >= AV_W'(len_eff));
        cfg_go    = idle && cfg_load;
        align_go  = idle && align_req && !cfg_load;
        rd_ready  = idle && !cfg_load && !align_req && enough;
        rd_stall  = idle && rd_valid && !enough;
        fire      = rd_valid && rd_ready;
        copy_go   = (st == ST_COPY) && !empty;
        fill_done = (st == ST_FILL) && mem_rsp_valid;
        over_end  = (st == ST_COPY) && empty && at_end;
        mem_req   = (st == ST_FILL);
        mem_addr  = next_addr;
        rsp_valid = (st == ST_RESP);
    end

    // Purpose: next-state logic of the read sequencer.
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE: if (fire) st_n = ST_COPY;
            ST_COPY: begin
                if (empty)              st_n = at_end ? ST_RESP : ST_FILL;
                else if (take == rem)   st_n = ST_RESP;
            end
            ST_FILL: if (mem_rsp_valid) st_n = ST_COPY;
            ST_RESP: st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    // Purpose: sequencer state, bytes still owed, sticky end error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            rem      <= '0;
            err_flag <= 1'b0;
        end else begin
            st <= st_n;
            if (fire)         rem <= len_eff;
            else if (copy_go) rem <= rem - take;
            if (cfg_go)        err_flag <= 1'b0;
            else if (over_end) err_flag <= 1'b1;
        end
    end

    qbr_src_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_go    (cfg_go),
        .cfg_start (cfg_start),
        .cfg_end   (cfg_end),
        .cfg_tag   (cfg_tag),
        .advance   (fill_done),
        .next_addr (next_addr),
        .remaining (remaining),
        .at_end    (at_end),
        .tag_pend  (tag_pend)
    );

    qbr_stage #(.BYTES(BYTES), .TAG_BYTES(TAG_BYTES), .ALIGN(ALIGN)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cfg_go),
        .load      (fill_done),
        .load_data (mem_rsp_data),
        .skip      (tag_pend),
        .consume   (copy_go),
        .take      (take),
        .align     (align_go),
        .qw        (qw),
        .pos       (pos),
        .empty     (empty)
    );

    qbr_gather #(.BYTES(BYTES)) u_gather (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (fire),
        .go    (copy_go),
        .src   (qw),
        .pos   (pos),
        .take  (take),
        .acc   (rsp_data)
    );

endmodule

// File: rtl/qbr_checker.sv
// Protocol and state checks for qw_byte_reader, attached by bind.
// Assumes the same parameter values as the bound instance.
module qbr_checker #(
    parameter int ADDR_W = 16,
    parameter int BYTES  = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cfg_load,
    input logic [$clog2(BYTES)-1:0] rd_len,
    input logic                     rd_ready,
    input logic                     rd_stall,
    input logic                     rsp_valid,
    input logic [ADDR_W:0]          avail_bytes,
    input logic                     err_flag,
    input logic                     mem_req,
    input logic [ADDR_W-1:0]        mem_addr,
    input logic                     mem_rsp_valid
);

    localparam int POS_W = $clog2(BYTES) + 1;

    logic [POS_W-1:0] want;

    // Purpose: byte count the current request asks for.
    always_comb begin
        want = (rd_len == '0) ? POS_W'(BYTES) : POS_W'(rd_len);
    end

    a_r8_ready_or_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_ready && rd_stall));

    a_r8_ready_has_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> (avail_bytes >= (ADDR_W+1)'(want)));

    a_r11_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr)));

    a_r7_avail_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> (avail_bytes <= $past(avail_bytes)));

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !cfg_load) |=> err_flag);

endmodule

bind qw_byte_reader qbr_checker #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_chk (.*);

// File: tb/sim_qw_byte_reader.sv
`timescale 1ns/1ps
module sim_qw_byte_reader;

    localparam int ADDR_W = 16;
    localparam int BYTES  = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_load, cfg_tag, align_req, rd_valid;
    logic [ADDR_W-1:0] cfg_start, cfg_end;
    logic [3:0]        rd_len;
    logic              rd_ready, rd_stall, rsp_valid, err_flag, mem_req;
    logic [127:0]      rsp_data;
    logic [ADDR_W:0]   avail_bytes;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rsp_valid;
    logic [127:0]      mem_rsp_data;

    int checks = 0;
    int errors = 0;
    int m_rp, m_end, m_next;
    bit m_tag, m_err;

    always #10 clk = ~clk;

    qw_byte_reader u0 (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_start(cfg_start),
        .cfg_end(cfg_end), .cfg_tag(cfg_tag), .align_req(align_req),
        .rd_valid(rd_valid), .rd_len(rd_len), .rd_ready(rd_ready),
        .rd_stall(rd_stall), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .avail_bytes(avail_bytes), .err_flag(err_flag), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 13) + (a >>> 8) + 7);
    endfunction

    task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int exp_avail();
        return m_end - m_rp + (m_tag ? 8 : 0);
    endfunction

    task automatic chk_state(string req);
        chk(int'(avail_bytes) == exp_avail(), {req, " R7 avail"}, avail_bytes, exp_avail());
        chk(err_flag == m_err, "R9 err_flag", err_flag, m_err);
    endtask

    // Memory responder: answers each fetch two cycles after it appears.
    initial begin : mem_server
        int cnt;
        cnt = 0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            if (mem_rsp_valid) begin
                mem_rsp_valid = 1'b0;
                cnt = 0;
            end else if (mem_req) begin
                cnt++;
                if (cnt == 2) begin
                    chk(int'(mem_addr) == m_next, "R4 fetch address", mem_addr, m_next);
                    for (int j = 0; j < 16; j++)
                        mem_rsp_data[8*j +: 8] = pat(int'(mem_addr) + j);
                    mem_rsp_valid = 1'b1;
                    m_next += 16;
                end
            end
        end
    end

    task automatic do_cfg(int start, int qws, bit tag);
        @(negedge clk);
        cfg_start = ADDR_W'(start);
        cfg_end   = ADDR_W'(start + 16 * qws);
        cfg_tag   = tag;
        cfg_load  = 1'b1;
        @(negedge clk);
        cfg_load  = 1'b0;
        m_rp = start + (tag ? 8 : 0);
        m_end = start + 16 * qws;
        m_next = start;
        m_tag = tag;
        m_err = 1'b0;
        #1;
        chk(int'(avail_bytes) == 16 * qws, "R2 avail after load", avail_bytes, 16 * qws);
        chk(err_flag == 1'b0, "R2 err cleared", err_flag, 0);
    endtask

    task automatic do_align();
        @(negedge clk);
        align_req = 1'b1;
        @(negedge clk);
        align_req = 1'b0;
        if (!m_tag) m_rp = (m_rp + 3) & ~3;
        #1;
        chk_state("R10");
    endtask

    // Returns 1 if the read was accepted.
    task automatic do_read(int n, output bit took);
        int av, real_left, got, t;
        logic [127:0] exp;
        av = exp_avail();
        @(negedge clk);
        rd_valid = 1'b1;
        rd_len   = 4'(n);
        #1;
        took = (n <= av);
        chk(rd_ready == took, "R8 rd_ready", rd_ready, took);
        chk(rd_stall == !took, "R8 rd_stall", rd_stall, !took);
        @(negedge clk);
        rd_valid = 1'b0;
        if (took) begin
            t = 0;
            while (!rsp_valid && t < 200) begin
                @(negedge clk);
                t++;
            end
            real_left = m_end - m_rp;
            got = (n < real_left) ? n : real_left;
            if (n > real_left) m_err = 1'b1;
            exp = '0;
            for (int j = 0; j < got; j++) exp[8*j +: 8] = pat(m_rp + j);
            chk(rsp_valid == 1'b1, "R11 response seen", rsp_valid, 1);
            chk(rsp_data == exp, m_tag ? "R3 R5 R6 data" : "R3 R5 data", rsp_data, exp);
            m_rp += got;
            m_tag = 1'b0;
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R11 single pulse", rsp_valid, 0);
        end
        #1;
        chk_state(took ? "R3" : "R8 stalled");
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit took;
        int step, n;
        rst_n = 1'b0; cfg_load = 1'b0; cfg_tag = 1'b0; align_req = 1'b0;
        rd_valid = 1'b0; rd_len = '0; cfg_start = '0; cfg_end = '0;
        m_rp = 0; m_end = 0; m_next = 0; m_tag = 1'b0; m_err = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(avail_bytes == '0, "R1 avail", avail_bytes, 0);
        chk(rsp_valid == 1'b0 && mem_req == 1'b0, "R1 outputs idle", {rsp_valid, mem_req}, 0);
        chk(err_flag == 1'b0, "R1 err", err_flag, 0);

        // R9: tagged single quadword, full read overruns the real data
        do_cfg(16'h100, 1, 1'b1);
        do_read(16, took);
        do_read(1, took);
        chk(err_flag == 1'b1, "R9 sticky", err_flag, 1);
        do_cfg(16'h100, 1, 1'b0);

        // Sweep over tag, size and base with varied lengths and alignment
        for (int tg = 0; tg < 2; tg++) begin
            for (int q = 1; q <= 4; q++) begin
                for (int s = 0; s < 3; s++) begin
                    do_cfg(s * 16'h3A0, q, tg[0]);
                    step = 0;
                    while (exp_avail() > 0 && step < 40) begin
                        n = ((step * 7 + q + s * 3 + tg) % 16) + 1;
                        do_read(n, took);
                        if (!took && exp_avail() > 0) do_read(exp_avail(), took);
                        if (step % 3 == 2) do_align();
                        step++;
                    end
                    do_read(1, took);
                    do_align();
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule